// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

The block gathers interrupt requests from five level-sensitive peripheral sources (controller A, controller B, an Ethernet controller, a serial controller and a sound controller), plus a pulsed non-maskable trigger. It presents a 3-bit priority level and a matching autovector number to a 68k-style CPU. Each request edge sets or clears one bit of a pending register. A priority encoder turns the highest pending bit into the level.

A mode input selects one of two routing maps. In the high mode, the Ethernet and sound requests do not reach the CPU path. They are steered to two auxiliary lines for a downstream controller, and the sound line is inverted so that a new request shows up there as a falling edge.

A non-maskable trigger pulse holds the top slot for a fixed 100 ms. The length of that hold is counted in clock cycles derived from the clock frequency parameter.

Top module: `irq_prio_router`

## Requirements
- R1: After reset, the outputs are: cpu_level_o = 0, cpu_vector_o = 0, aux_eth_o = 0 and aux_snd_o = 1. Reset also clears the stored mode to low, clears every pending slot and cancels a running non-maskable hold.
- R2: With the stored mode low, the asserted levels are: controller A 6, controller B 2, Ethernet 3, serial 4 and sound 5. In this mode aux_eth_o stays 0 and aux_snd_o stays 1.
- R3: With the stored mode high, the asserted levels are: controller A 1, controller B 2 and serial 4.
- R4: With the stored mode high, aux_eth_o follows the Ethernet request one cycle after it is sampled, and the Ethernet request leaves the CPU level unchanged.
- R5: With the stored mode high, aux_snd_o is the inverse of the sound request, one cycle after it is sampled, and the sound request leaves the CPU level unchanged.
- R6: cpu_level_o equals the index of the highest pending slot plus one. cpu_vector_o equals cpu_level_o + 24, and is 0 when cpu_level_o is 0. When several sources are active, the highest level wins.
- R7: A rising request edge sets its slot and a falling request edge clears it. Once all mapped requests are low, cpu_level_o returns to 0.
- R8: A change of the mode input only updates the stored mode. A slot already pending stays pending, at the same level.
- R9: A non-maskable trigger sampled at edge T sets slot 6 (level 7, vector 31) at that edge. The slot clears at edge T+H, where H = CLK_HZ/1000 × HOLD_MS.
- R10: A trigger sampled while the hold is running restarts the count of H cycles from that edge.
- R11: cpu_level_o and cpu_vector_o are registered. They reflect a request sampled at edge k from edge k+1 on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Routing map select (0: all sources to CPU, 1: Ethernet and sound diverted) |
| req_a_i | input | 1 | Controller A request |
| req_b_i | input | 1 | Controller B request |
| req_eth_i | input | 1 | Ethernet request |
| req_ser_i | input | 1 | Serial request |
| req_snd_i | input | 1 | Sound request |
| nmi_trig_i | input | 1 | Non-maskable trigger pulse |
| cpu_level_o | output | 3 | Priority level to the CPU, 0 = none |
| cpu_vector_o | output | 8 | Autovector number, level + 24, 0 when idle |
| aux_eth_o | output | 1 | Ethernet request, passed through in mode high |
| aux_snd_o | output | 1 | Inverted sound request in mode high, idle high |

## Verification
The assertions check these relations on every cycle:
- the vector tracks the level;
- the level names the highest slot pending one cycle before, and is zero when nothing was pending;
- the auxiliary lines only ever reflect a request sampled the cycle before;
- a trigger sets the top slot and then level 7.

Only the bench scenarios can show:
- the two routing maps level by level;
- that a slot pending across a mode change keeps its level;
- the exact release edge of the hold;
- the restart on a second trigger;
- that reset cancels a running hold.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NUM_SLOTS = 7;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int NUM_SRC   = 5;
    localparam int NMI_SLOT  = 6;

    localparam int SRC_A   = 0;
    localparam int SRC_B   = 1;
    localparam int SRC_ETH = 2;
    localparam int SRC_SER = 3;
    localparam int SRC_SND = 4;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } route_t;

    // slot a source lands in for a given map; hit = 0 means diverted
    function automatic route_t route_of(input logic mode, input int src);
        route_t r;
        r.hit  = 1'b1;
        r.slot = '0;
        case (src)
            SRC_A:   r.slot = mode ? SLOT_W'(0) : SLOT_W'(5);
            SRC_B:   r.slot = SLOT_W'(1);
            SRC_ETH: begin r.slot = SLOT_W'(2); r.hit = ~mode; end
            SRC_SER: r.slot = SLOT_W'(3);
            SRC_SND: begin r.slot = SLOT_W'(4); r.hit = ~mode; end
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_router.sv
module irq_edge_router
    import irq_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic [NUM_SRC-1:0]   req_i,
    output logic [NUM_SLOTS-1:0] set_o,
    output logic [NUM_SLOTS-1:0] clr_o,
    output logic                 aux_eth_o,
    output logic                 aux_snd_o
);

    typedef struct packed {
        logic               mode;
        logic [NUM_SRC-1:0] req;
    } rt_state_t;

    rt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        st_d.req  = req_i;
        set_o     = '0;
        clr_o     = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            route_t r;
            r = route_of(st_q.mode, s);
            if (r.hit && (req_i[s] != st_q.req[s])) begin
                if (req_i[s]) set_o[r.slot] = 1'b1;
                else          clr_o[r.slot] = 1'b1;
            end
        end
        aux_eth_o = st_q.mode & st_q.req[SRC_ETH];
        aux_snd_o = ~(st_q.mode & st_q.req[SRC_SND]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/nmi_hold_timer.sv
module nmi_hold_timer #(
    parameter int HOLD_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic expire_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i)                st_d.cnt = CW'(HOLD_CYC);
        else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - CW'(1);
        expire_o = (st_q.cnt == CW'(1)) && !trig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/prio_level_enc.sv
module prio_level_enc #(
    parameter int NSLOT = 7,
    parameter int LW    = $clog2(NSLOT + 1)
) (
    input  logic [NSLOT-1:0] pend_i,
    output logic [LW-1:0]    level_o
);

    always_comb begin
        level_o = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pend_i[i]) level_o = LW'(i + 1);
        end
    end

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
    import irq_router_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int HOLD_MS  = 100,
    parameter int VEC_BASE = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_i,
    input  logic       req_a_i,
    input  logic       req_b_i,
    input  logic       req_eth_i,
    input  logic       req_ser_i,
    input  logic       req_snd_i,
    input  logic       nmi_trig_i,
    output logic [2:0] cpu_level_o,
    output logic [7:0] cpu_vector_o,
    output logic       aux_eth_o,
    output logic       aux_snd_o
);

    localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
    localparam int LW       = $clog2(NUM_SLOTS + 1);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] pending;
        logic [LW-1:0]        level;
        logic [7:0]           vector;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_SRC-1:0]   req_vec;
    logic [NUM_SLOTS-1:0] rt_set, rt_clr;
    logic                 nmi_expire;
    logic [LW-1:0]        enc_level;
    logic [NUM_SLOTS-1:0] pending_q;

    assign req_vec = {req_snd_i, req_ser_i, req_eth_i, req_b_i, req_a_i};

    irq_edge_router u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .req_i     (req_vec),
        .set_o     (rt_set),
        .clr_o     (rt_clr),
        .aux_eth_o (aux_eth_o),
        .aux_snd_o (aux_snd_o)
    );

    nmi_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (nmi_trig_i),
        .expire_o (nmi_expire)
    );

    prio_level_enc #(.NSLOT(NUM_SLOTS), .LW(LW)) u_enc (
        .pend_i  (st_q.pending),
        .level_o (enc_level)
    );

    always_comb begin
        logic [NUM_SLOTS-1:0] set_all, clr_all;
        st_d    = st_q;
        set_all = rt_set;
        clr_all = rt_clr;
        if (nmi_trig_i) set_all[NMI_SLOT] = 1'b1;
        if (nmi_expire) clr_all[NMI_SLOT] = 1'b1;
        st_d.pending = (st_q.pending & ~clr_all) | set_all;
        st_d.level   = enc_level;
        st_d.vector  = (enc_level == '0) ? 8'd0 : 8'(VEC_BASE) + 8'(enc_level);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_q    = st_q.pending;
    assign cpu_level_o  = st_q.level;
    assign cpu_vector_o = st_q.vector;

endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_eth_i,
    input logic       req_snd_i,
    input logic       nmi_trig_i,
    input logic [6:0] pending_q,
    input logic [2:0] cpu_level_o,
    input logic [7:0] cpu_vector_o,
    input logic       aux_eth_o,
    input logic       aux_snd_o
);

    a_r6_vector_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vector_o == ((cpu_level_o == 3'd0) ? 8'd0 : 8'd24 + 8'(cpu_level_o)));

    a_r6_level_is_highest: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level_o != 3'd0) |-> (($past(pending_q) >> (cpu_level_o - 3'd1)) == 7'd1));

    a_r6_idle_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q == 7'd0) |=> (cpu_level_o == 3'd0));

    a_r4_aux_eth_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        aux_eth_o |-> $past(req_eth_i));

    a_r5_aux_snd_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_snd_o |-> $past(req_snd_i));

    a_r9_trigger_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_trig_i |=> pending_q[6]);

    a_r9_trigger_gives_level7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_trig_i |=> ##1 (cpu_level_o == 3'd7));

endmodule

bind irq_prio_router irq_prio_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_eth_i    (req_eth_i),
    .req_snd_i    (req_snd_i),
    .nmi_trig_i   (nmi_trig_i),
    .pending_q    (pending_q),
    .cpu_level_o  (cpu_level_o),
    .cpu_vector_o (cpu_vector_o),
    .aux_eth_o    (aux_eth_o),
    .aux_snd_o    (aux_snd_o)
);

// File: tb/irq_prio_router_test.sv
module irq_prio_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 2000;
    localparam int T_HOLD_MS  = 100;
    localparam int H          = (T_CLK_HZ / 1000) * T_HOLD_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic ra = 1'b0, rb = 1'b0, re = 1'b0, rs = 1'b0, rn = 1'b0, nmi = 1'b0;
    logic [2:0] lvl;
    logic [7:0] vec;
    logic aeth, asnd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_router #(.CLK_HZ(T_CLK_HZ), .HOLD_MS(T_HOLD_MS)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .req_a_i(ra), .req_b_i(rb), .req_eth_i(re), .req_ser_i(rs), .req_snd_i(rn),
        .nmi_trig_i(nmi),
        .cpu_level_o(lvl), .cpu_vector_o(vec), .aux_eth_o(aeth), .aux_snd_o(asnd)
    );

    function automatic int exp_level(input bit m, input bit a, input bit b,
                                     input bit e, input bit s, input bit n);
        int l = 0;
        if (!m) begin
            if (b && l < 2) l = 2;
            if (e && l < 3) l = 3;
            if (s && l < 4) l = 4;
            if (n && l < 5) l = 5;
            if (a && l < 6) l = 6;
        end else begin
            if (a && l < 1) l = 1;
            if (b && l < 2) l = 2;
            if (s && l < 4) l = 4;
        end
        return l;
    endfunction

    function automatic int exp_vec(input int l);
        return (l == 0) ? 0 : l + 24;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input int el, input int ee, input int es);
        chk(req, int'(lvl), el);
        chk(req, int'(vec), exp_vec(el));
        chk(req, int'(aeth), ee);
        chk(req, int'(asnd), es);
    endtask

    task automatic drive(input bit a, input bit b, input bit e, input bit s, input bit n);
        ra = a; rb = b; re = e; rs = s; rn = n;
    endtask

    task automatic nmi_pulse();
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
    endtask

    task automatic random_phase(input bit m, input string req);
        for (int i = 0; i < 40; i++) begin
            logic [4:0] p;
            p = 5'($urandom);
            drive(p[0], p[1], p[2], p[3], p[4]);
            wait_cyc(2);
            check_all(req, exp_level(m, p[0], p[1], p[2], p[3], p[4]),
                      int'(m & p[2]), int'(!(m & p[4])));
        end
        drive(0, 0, 0, 0, 0);
        wait_cyc(2);
        check_all("R7", 0, 0, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check_all("R1", 0, 0, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: level appears exactly one edge after the pending edge
        ra = 1'b1;
        wait_cyc(1);
        chk("R11", int'(lvl), 0);
        wait_cyc(1);
        chk("R11", int'(lvl), 6);
        ra = 1'b0;
        wait_cyc(2);

        // R2 directed low-mode levels
        drive(0, 1, 0, 0, 0); wait_cyc(2); check_all("R2", 2, 0, 1);
        drive(0, 0, 1, 0, 0); wait_cyc(2); check_all("R2", 3, 0, 1);
        drive(0, 0, 0, 1, 0); wait_cyc(2); check_all("R2", 4, 0, 1);
        drive(0, 0, 0, 0, 1); wait_cyc(2); check_all("R2", 5, 0, 1);
        // R6 several active: highest wins
        drive(1, 1, 1, 1, 1); wait_cyc(2); check_all("R6", 6, 0, 1);
        drive(0, 1, 1, 0, 0); wait_cyc(2); check_all("R6", 3, 0, 1);
        drive(0, 0, 0, 0, 0); wait_cyc(2); check_all("R7", 0, 0, 1);

        random_phase(1'b0, "R2");

        // R8 pending slot survives a mode change
        ra = 1'b1; wait_cyc(2);
        mode = 1'b1; wait_cyc(3);
        chk("R8", int'(lvl), 6);
        mode = 1'b0; wait_cyc(2);
        ra = 1'b0; wait_cyc(2);
        chk("R8", int'(lvl), 0);

        mode = 1'b1; wait_cyc(2);
        // R3 directed high-mode levels
        drive(1, 0, 0, 0, 0); wait_cyc(2); check_all("R3", 1, 0, 1);
        drive(0, 1, 0, 0, 0); wait_cyc(2); check_all("R3", 2, 0, 1);
        drive(0, 0, 0, 1, 0); wait_cyc(2); check_all("R3", 4, 0, 1);
        // R4 / R5 diversion and inversion
        drive(0, 0, 1, 0, 0); wait_cyc(2); check_all("R4", 0, 1, 1);
        drive(0, 0, 0, 0, 1); wait_cyc(2); check_all("R5", 0, 0, 0);
        drive(1, 0, 1, 0, 1); wait_cyc(2); check_all("R5", 1, 1, 0);
        drive(0, 0, 0, 0, 0); wait_cyc(2); check_all("R7", 0, 0, 1);

        random_phase(1'b1, "R3");
        mode = 1'b0; wait_cyc(2);

        // R9 hold and release edge
        nmi_pulse();
        wait_cyc(1);
        check_all("R9", 7, 0, 1);
        wait_cyc(H - 1);
        chk("R9", int'(lvl), 7);
        wait_cyc(1);
        chk("R9", int'(lvl), 0);

        // R10 retrigger restarts count
        nmi_pulse();
        wait_cyc(99);
        nmi_pulse();
        wait_cyc(H);
        chk("R10", int'(lvl), 7);
        wait_cyc(1);
        chk("R10", int'(lvl), 0);

        // R1 reset cancels running hold and clears mode
        mode = 1'b1;
        rn = 1'b1;
        nmi_pulse();
        wait_cyc(10);
        mode = 1'b0;
        rst_n = 1'b0;
        wait_cyc(2);
        rn = 1'b0;
        rst_n = 1'b1;
        wait_cyc(2);
        check_all("R1", 0, 0, 1);
        wait_cyc(H);
        chk("R1", int'(lvl), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule